// File: doc/BRIEF.md
# Banked Prioritized Interrupt Controller

This block collects up to 128 level-sensitive interrupt sources, organised as banks of 32, and presents the most urgent one to a processor on either a normal interrupt line (`irq`) or a fast interrupt line (`fiq`). Each source has its own programmable 6-bit priority and a route bit that chooses between the two lines. Software can mask sources, inject software interrupts, and read raw and pending views through a 32-bit word-wide register port.

The irq and fiq paths each have an arbiter. When its line is idle, an arbiter picks the pending source with the best priority and latches that source's number into an active register. The line stays asserted and the number stays frozen until software writes an acknowledge. On that write the arbiter re-runs at once over the current pending set. Inputs are sampled into a register first. Read data is registered and follows `addr` one cycle later. Only word-aligned accesses (`addr[1:0] == 0`) decode.

Top module: `irq_ctrl_banked`

## Requirements
- R1: After reset, `irq` and `fiq` are low. Every bank mask reads 0xFFFFFFFF, every level register reads 0, both active registers (0x40 irq, 0x44 fiq) read 0xFF (bit 7 = no-winner flag, bits [6:0] = 0x7F), and 0x00 reads {REV_MAJOR in [7:4], REV_MINOR in [3:0]}.
- R2: Source s belongs to bank s[6:5] at bit s[4:0]. Bank n occupies 0x80+0x20·n, and word +0x00 of a bank returns the sampled input levels.
- R3: Bank word +0x04 writes the mask directly. In +0x0C (set) and +0x08 (clear), each 1 bit sets or clears that mask bit and each 0 bit leaves it alone. A mask bit of 1 blocks its source.
- R4: A 1 written to bank word +0x10 raises a software request for that source, which then behaves as if its input were high. A 1 written to +0x14 drops it. Word +0x10 reads back the software requests.
- R5: Bank word +0x18 reads (input OR software) AND NOT mask for sources routed to irq. Word +0x1C reads the same for sources routed to fiq.
- R6: The level register of source s is at 0x100+4·s. Bit 0 = 1 routes to fiq and 0 routes to irq. Bits [7:2] hold the priority, with 0 most urgent. Bit 1 and bits [31:8] read 0.
- R7: The arbiter picks the pending source with the numerically lowest priority. On a tie, the lower source number wins.
- R8: Once a winner is latched, its line stays high and its active register reads {0, number}. Neither changes until acknowledge, even if pending sources or levels change.
- R9: Writing 0x48 with bit 0 set acknowledges irq, and bit 1 acknowledges fiq. On that edge the arbiter latches a new winner if one is pending. Otherwise the line falls and the active register returns to 0xFF. Each path is independent of the other.
- R10: Sources routed to fiq are arbitrated separately. Their winner is reported at 0x44 and on `fiq`.
- R11: 0x10 bit 0 is a readable idle-enable bit. Writing 0x10 with bit 1 set performs a soft reset, which restores the R1 state. 0x14 bit 0 reads 1 once that reset has completed.
- R12: With NUM_SRC = 96, the addresses of bank 3 and the level registers of sources 96 and above read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Level-sensitive interrupt inputs |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 10 | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the previous cycle's address |
| irq | output | 1 | Normal interrupt line |
| fiq | output | 1 | Fast interrupt line |

## Verification
The bench builds the controller with NUM_SRC = 96, which gives three banks. This makes the absent fourth bank and the level registers above source 95 reachable, so R12 can be checked at the ports. The three banks still let a source in a high bank (source 70) win arbitration. This exercises the bank and bit split of the source number. Revision fields keep their defaults, so the revision readback has a known value.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int BANK_W = 32;
  localparam int PRI_W  = 6;
  localparam int ID_W   = 7;
  localparam int ADDR_W = 10;
  localparam int WORD_W = ADDR_W - 2;

  // word (addr[9:2]) indexes of the single registers
  localparam logic [WORD_W-1:0] W_REV     = 8'h00;
  localparam logic [WORD_W-1:0] W_SYSCFG  = 8'h04;
  localparam logic [WORD_W-1:0] W_SYSSTAT = 8'h05;
  localparam logic [WORD_W-1:0] W_ACT_IRQ = 8'h10;
  localparam logic [WORD_W-1:0] W_ACT_FIQ = 8'h11;
  localparam logic [WORD_W-1:0] W_CTRL    = 8'h12;
  localparam logic [WORD_W-1:0] W_LVL     = 8'h40;

  localparam logic [ID_W:0] ACT_NONE = 8'hFF;

  typedef enum logic [2:0] {
    B_RAW   = 3'd0,
    B_MASK  = 3'd1,
    B_MCLR  = 3'd2,
    B_MSET  = 3'd3,
    B_SWSET = 3'd4,
    B_SWCLR = 3'd5,
    B_PIRQ  = 3'd6,
    B_PFIQ  = 3'd7
  } bank_off_e;
endpackage

// File: rtl/irq_bank_regs.sv
module irq_bank_regs
  import irq_ctrl_pkg::*;
#(
  parameter int WIDTH = BANK_W
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             we,
  input  bank_off_e        off,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] swi
);
  always_ff @(posedge clk) begin
    if (srst) begin
      mask <= '1;
      swi  <= '0;
    end else if (we) begin
      case (off)
        B_MASK:  mask <= wdata;
        B_MCLR:  mask <= mask & ~wdata;
        B_MSET:  mask <= mask | wdata;
        B_SWSET: swi  <= swi | wdata;
        B_SWCLR: swi  <= swi & ~wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_level_file.sv
module irq_level_file #(
  parameter int NUM_SRC = 128,
  parameter int PRI_W   = 6,
  parameter int IDX_W   = 8
) (
  input  logic                     clk,
  input  logic                     srst,
  input  logic                     we,
  input  logic [IDX_W-1:0]         idx,
  input  logic [PRI_W-1:0]         pri_in,
  input  logic                     route_in,
  output logic [NUM_SRC*PRI_W-1:0] pri_flat,
  output logic [NUM_SRC-1:0]       route
);
  // every priority feeds the arbiters in parallel, so these live in flops
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (srst) begin
        pri_flat[i*PRI_W +: PRI_W] <= '0;
        route[i]                   <= 1'b0;
      end else if (we && idx == IDX_W'(i)) begin
        pri_flat[i*PRI_W +: PRI_W] <= pri_in;
        route[i]                   <= route_in;
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC = 128,
  parameter int PRI_W   = 6,
  parameter int ID_W    = 7
) (
  input  logic                     clk,
  input  logic                     srst,
  input  logic [NUM_SRC-1:0]       pend,
  input  logic [NUM_SRC*PRI_W-1:0] pri_flat,
  input  logic                     ack,
  output logic [ID_W-1:0]          act_id,
  output logic                     act_valid
);
  logic             found;
  logic [PRI_W-1:0] best_pri;
  logic [ID_W-1:0]  best_id;

  // scan from source 0 upward; strict compare keeps the lower number on ties
  always_comb begin
    found    = 1'b0;
    best_pri = '1;
    best_id  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && (!found || pri_flat[i*PRI_W +: PRI_W] < best_pri)) begin
        found    = 1'b1;
        best_pri = pri_flat[i*PRI_W +: PRI_W];
        best_id  = ID_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      act_valid <= 1'b0;
      act_id    <= '1;
    end else if (ack || !act_valid) begin
      act_valid <= found;
      act_id    <= found ? best_id : '1;
    end
  end
endmodule

// File: rtl/irq_ctrl_banked.sv
module irq_ctrl_banked
  import irq_ctrl_pkg::*;
#(
  parameter int         NUM_SRC   = 128,
  parameter logic [3:0] REV_MAJOR = 4'd2,
  parameter logic [3:0] REV_MINOR = 4'd1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               irq,
  output logic               fiq
);
  localparam int NUM_BANKS = NUM_SRC / BANK_W;

  logic soft_q, srst, idle_en;
  logic [NUM_SRC-1:0] src_q, mask_all, swi_all, route_all;
  logic [NUM_SRC-1:0] pend_all, pend_irq, pend_fiq;
  logic [NUM_SRC*PRI_W-1:0] pri_flat;
  logic [ID_W-1:0] irq_id, fiq_id;
  logic irq_valid, fiq_valid, irq_ack, fiq_ack;

  // ---------------- address decode ----------------
  logic              aligned;
  logic [WORD_W-1:0] word;
  logic              bank_ok, lvl_ok, wr_ok;
  logic [1:0]        bank_sel;
  bank_off_e         bank_off;
  logic [WORD_W-1:0] lvl_idx;

  assign aligned  = (addr[1:0] == 2'b00);
  assign word     = addr[ADDR_W-1:2];
  assign wr_ok    = wr_en && aligned;
  assign bank_sel = addr[6:5];
  assign bank_off = bank_off_e'(addr[4:2]);
  assign bank_ok  = aligned && (addr[9:7] == 3'b001) && (32'(bank_sel) < NUM_BANKS);
  assign lvl_idx  = word - W_LVL;
  assign lvl_ok   = aligned && (addr[9:8] != 2'b00) && (32'(lvl_idx) < NUM_SRC);

  assign irq_ack  = wr_ok && word == W_CTRL && wdata[0];
  assign fiq_ack  = wr_ok && word == W_CTRL && wdata[1];

  // ---------------- system control ----------------
  always_ff @(posedge clk) begin
    if (rst) soft_q <= 1'b0;
    else     soft_q <= wr_ok && word == W_SYSCFG && wdata[1];
  end
  assign srst = rst || soft_q;

  always_ff @(posedge clk) begin
    if (srst)                              idle_en <= 1'b0;
    else if (wr_ok && word == W_SYSCFG)    idle_en <= wdata[0];
  end

  always_ff @(posedge clk) begin
    if (srst) src_q <= '0;
    else      src_q <= src_in;
  end

  // ---------------- banks ----------------
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irq_bank_regs #(.WIDTH(BANK_W)) u_bank (
      .clk   (clk),
      .srst  (srst),
      .we    (wr_en && bank_ok && bank_sel == 2'(b)),
      .off   (bank_off),
      .wdata (wdata),
      .mask  (mask_all[b*BANK_W +: BANK_W]),
      .swi   (swi_all[b*BANK_W +: BANK_W])
    );
  end

  irq_level_file #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W), .IDX_W(WORD_W)) u_lvl (
    .clk      (clk),
    .srst     (srst),
    .we       (wr_en && lvl_ok),
    .idx      (lvl_idx),
    .pri_in   (wdata[7:2]),
    .route_in (wdata[0]),
    .pri_flat (pri_flat),
    .route    (route_all)
  );

  assign pend_all = (src_q | swi_all) & ~mask_all;
  assign pend_irq = pend_all & ~route_all;
  assign pend_fiq = pend_all & route_all;

  // ---------------- arbiters ----------------
  irq_arbiter #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W), .ID_W(ID_W)) u_arb_irq (
    .clk       (clk),
    .srst      (srst),
    .pend      (pend_irq),
    .pri_flat  (pri_flat),
    .ack       (irq_ack),
    .act_id    (irq_id),
    .act_valid (irq_valid)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W), .ID_W(ID_W)) u_arb_fiq (
    .clk       (clk),
    .srst      (srst),
    .pend      (pend_fiq),
    .pri_flat  (pri_flat),
    .ack       (fiq_ack),
    .act_id    (fiq_id),
    .act_valid (fiq_valid)
  );

  assign irq = irq_valid;
  assign fiq = fiq_valid;

  // ---------------- read path ----------------
  logic [31:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (lvl_ok) begin
      for (int i = 0; i < NUM_SRC; i++)
        if (lvl_idx == WORD_W'(i))
          rd_next = {24'b0, pri_flat[i*PRI_W +: PRI_W], 1'b0, route_all[i]};
    end else if (bank_ok) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bank_sel == 2'(b)) begin
          case (bank_off)
            B_RAW:   rd_next = src_q[b*BANK_W +: BANK_W];
            B_MASK:  rd_next = mask_all[b*BANK_W +: BANK_W];
            B_SWSET: rd_next = swi_all[b*BANK_W +: BANK_W];
            B_PIRQ:  rd_next = pend_irq[b*BANK_W +: BANK_W];
            B_PFIQ:  rd_next = pend_fiq[b*BANK_W +: BANK_W];
            default: rd_next = '0;
          endcase
        end
      end
    end else if (aligned) begin
      case (word)
        W_REV:     rd_next = {24'b0, REV_MAJOR, REV_MINOR};
        W_SYSCFG:  rd_next = {31'b0, idle_en};
        W_SYSSTAT: rd_next = {31'b0, ~soft_q};
        W_ACT_IRQ: rd_next = irq_valid ? {25'b0, irq_id} : {24'b0, ACT_NONE};
        W_ACT_FIQ: rd_next = fiq_valid ? {25'b0, fiq_id} : {24'b0, ACT_NONE};
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 128
) (
  input logic               clk,
  input logic               srst,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [31:0]        wdata,
  input logic               irq,
  input logic               fiq,
  input logic [ID_W-1:0]    irq_id,
  input logic [ID_W-1:0]    fiq_id,
  input logic [NUM_SRC-1:0] mask_all,
  input logic [NUM_SRC-1:0] route_all,
  input logic [NUM_SRC-1:0] pend_irq,
  input logic               irq_ack,
  input logic               fiq_ack
);
  logic [NUM_SRC-1:0] pend_irq_q, route_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      pend_irq_q <= '0;
      route_q    <= '0;
    end else begin
      pend_irq_q <= pend_irq;
      route_q    <= route_all;
    end
  end

  // R3: set alias forces the written ones high in bank 0
  assert_mask_set_R3: assert property (@(posedge clk) disable iff (srst)
    (wr_en && addr == 10'h08C) |=> ((mask_all[31:0] & $past(wdata)) == $past(wdata)));

  // R3: clear alias forces the written ones low in bank 0
  assert_mask_clr_R3: assert property (@(posedge clk) disable iff (srst)
    (wr_en && addr == 10'h088) |=> ((mask_all[31:0] & $past(wdata)) == 32'h0));

  // R8: irq winner frozen until acknowledged
  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (srst)
    (irq && !irq_ack) |=> (irq && $stable(irq_id)));

  // R8: fiq winner frozen until acknowledged
  assert_fiq_hold_R8: assert property (@(posedge clk) disable iff (srst)
    (fiq && !fiq_ack) |=> (fiq && $stable(fiq_id)));

  // R5: a newly raised irq names a source that was pending for irq
  assert_irq_pend_R5: assert property (@(posedge clk) disable iff (srst)
    $rose(irq) |-> pend_irq_q[irq_id]);

  // R10: a newly raised fiq names a source routed to fiq
  assert_fiq_route_R10: assert property (@(posedge clk) disable iff (srst)
    $rose(fiq) |-> route_q[fiq_id]);

  // R9: ack with nothing pending drops the line
  assert_ack_drop_R9: assert property (@(posedge clk) disable iff (srst)
    (irq_ack && pend_irq == '0) |=> !irq);
endmodule

bind irq_ctrl_banked irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .srst      (srst),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata     (wdata),
  .irq       (irq),
  .fiq       (fiq),
  .irq_id    (irq_id),
  .fiq_id    (fiq_id),
  .mask_all  (mask_all),
  .route_all (route_all),
  .pend_irq  (pend_irq),
  .irq_ack   (irq_ack),
  .fiq_ack   (fiq_ack)
);

// File: tb/tb_irq_ctrl_banked.sv
`timescale 1ns/1ps
module tb_irq_ctrl_banked;
  localparam int NSRC = 96;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_in = '0;
  logic            wr_en = 1'b0;
  logic [9:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            irq, fiq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_ctrl_banked #(.NUM_SRC(NSRC)) dut (
    .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .fiq(fiq)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_DRV = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [9:0]  a;
    logic [31:0] d;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 53;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,  10'h084, 32'hFFFFFFFF, 4'd1},  // R1 mask reset
    '{OP_RD,  10'h040, 32'h000000FF, 4'd1},  // R1 active irq none
    '{OP_RD,  10'h044, 32'h000000FF, 4'd1},  // R1 active fiq none
    '{OP_RD,  10'h000, 32'h00000021, 4'd1},  // R1 revision
    '{OP_RD,  10'h104, 32'h00000000, 4'd1},  // R1 level reset
    '{OP_WR,  10'h088, 32'h0000000F, 4'd3},
    '{OP_RD,  10'h084, 32'hFFFFFFF0, 4'd3},  // R3 clear alias
    '{OP_WR,  10'h08C, 32'h00000003, 4'd3},
    '{OP_RD,  10'h084, 32'hFFFFFFF3, 4'd3},  // R3 set alias
    '{OP_WR,  10'h088, 32'h00000000, 4'd3},
    '{OP_RD,  10'h084, 32'hFFFFFFF3, 4'd3},  // R3 zeros ignored
    '{OP_WR,  10'h084, 32'hFFFFFFF0, 4'd3},
    '{OP_RD,  10'h084, 32'hFFFFFFF0, 4'd3},  // R3 direct write
    '{OP_DRV, 10'h000, 32'h00000005, 4'd2},
    '{OP_RD,  10'h080, 32'h00000005, 4'd2},  // R2 raw view
    '{OP_RD,  10'h098, 32'h00000005, 4'd5},  // R5 pending irq
    '{OP_RD,  10'h09C, 32'h00000000, 4'd5},  // R5 pending fiq empty
    '{OP_RD,  10'h040, 32'h00000000, 4'd7},  // R7 tie -> lower number
    '{OP_WR,  10'h108, 32'h00000014, 4'd6},
    '{OP_WR,  10'h100, 32'h00000024, 4'd6},
    '{OP_RD,  10'h040, 32'h00000000, 4'd8},  // R8 held despite better source
    '{OP_WR,  10'h048, 32'h00000001, 4'd9},
    '{OP_RD,  10'h040, 32'h00000002, 4'd9},  // R9 re-arbitrate, R7 priority
    '{OP_RD,  10'h108, 32'h00000014, 4'd6},  // R6 readback
    '{OP_WR,  10'h108, 32'h00000015, 4'd6},
    '{OP_RD,  10'h09C, 32'h00000004, 4'd5},  // R5 fiq route
    '{OP_RD,  10'h098, 32'h00000001, 4'd5},  // R5 irq route
    '{OP_RD,  10'h044, 32'h00000002, 4'd10}, // R10 fiq winner
    '{OP_RD,  10'h040, 32'h00000002, 4'd8},  // R8 held through reroute
    '{OP_WR,  10'h048, 32'h00000001, 4'd9},
    '{OP_RD,  10'h040, 32'h00000000, 4'd9},  // R9 next irq winner
    '{OP_RD,  10'h044, 32'h00000002, 4'd9},  // R9 fiq untouched
    '{OP_DRV, 10'h000, 32'h00000000, 4'd4},
    '{OP_WR,  10'h090, 32'h00000008, 4'd4},
    '{OP_RD,  10'h090, 32'h00000008, 4'd4},  // R4 sw readback
    '{OP_RD,  10'h098, 32'h00000008, 4'd4},  // R4 sw acts as input
    '{OP_WR,  10'h048, 32'h00000003, 4'd9},
    '{OP_RD,  10'h040, 32'h00000003, 4'd4},  // R4 sw source wins
    '{OP_RD,  10'h044, 32'h000000FF, 4'd9},  // R9 fiq none pending
    '{OP_WR,  10'h094, 32'h00000008, 4'd4},
    '{OP_RD,  10'h090, 32'h00000000, 4'd4},  // R4 sw clear
    '{OP_WR,  10'h048, 32'h00000001, 4'd9},
    '{OP_RD,  10'h040, 32'h000000FF, 4'd9},  // R9 empty after ack
    '{OP_WR,  10'h0C8, 32'h00000040, 4'd2},
    '{OP_DRV, 10'h002, 32'h00000040, 4'd2},
    '{OP_RD,  10'h0C0, 32'h00000040, 4'd2},  // R2 bank 2 raw
    '{OP_RD,  10'h040, 32'h00000046, 4'd2},  // R2 source 70 number
    '{OP_WR,  10'h0E8, 32'hFFFFFFFF, 4'd12},
    '{OP_RD,  10'h0E4, 32'h00000000, 4'd12}, // R12 absent bank
    '{OP_WR,  10'h27C, 32'h000000FF, 4'd6},
    '{OP_RD,  10'h27C, 32'h000000FD, 4'd6},  // R6 bit1 reads 0
    '{OP_WR,  10'h280, 32'h000000FF, 4'd12},
    '{OP_RD,  10'h280, 32'h00000000, 4'd12}  // R12 absent level
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string rq);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string rq);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    check(rdata, exp, rq);
  endtask

  task automatic drv(input int bank, input logic [31:0] d);
    @(negedge clk);
    src_in[bank*32 +: 32] = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({31'b0, irq}, 32'd0, "R1 irq low");
    check({31'b0, fiq}, 32'd0, "R1 fiq low");

    for (int k = 0; k < NV; k++) begin
      case (VECS[k].op)
        OP_WR:  wr(VECS[k].a, VECS[k].d);
        OP_DRV: drv(int'(VECS[k].a), VECS[k].d);
        default: rd(VECS[k].a, VECS[k].d,
                    $sformatf("R%0d addr=%h", VECS[k].req, VECS[k].a));
      endcase
    end

    // source 70 latched on irq, nothing on fiq
    check({31'b0, irq}, 32'd1, "R8 irq line high");
    check({31'b0, fiq}, 32'd0, "R10 fiq line low");

    // R11 idle-enable bit and soft reset
    wr(10'h010, 32'h1);
    rd(10'h010, 32'h1, "R11 idle enable");
    wr(10'h010, 32'h2);
    rd(10'h014, 32'h1, "R11 reset done");
    rd(10'h010, 32'h0, "R11 idle cleared");
    rd(10'h0C4, 32'hFFFFFFFF, "R11 mask restored");
    rd(10'h108, 32'h0, "R11 level cleared");
    rd(10'h040, 32'hFF, "R11 active cleared");
    check({31'b0, irq}, 32'd0, "R11 irq low");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule